// File: doc/BRIEF.md
# Programmable SPI Slave Test Responder

This block is an SPI slave meant to sit opposite an SPI master under test. A host programs the clock mode, the bit order, the symbol width and the duplex mode through a four-word register port. The master then runs transfers against it. The responder answers in a way that is known in advance, so the master's receive path can be checked. It also tallies what it received, so the master's transmit path can be checked.

In full duplex the slave echoes, on MISO, the symbol it received one slot earlier. In half duplex the data line on the master's MOSI pin is shared. The slave first listens for a programmed number of symbols. It then drives a programmed number of symbols back on the same line and releases it afterwards. Two statistics can be read back by the host at any time: a 16-bit count of completed transfers and a 32-bit sum of the received bytes. A control-register write clears both.

All SPI pins are brought into the system clock domain through synchronisers. SCLK must therefore run at no more than a quarter of the system clock rate.

Top module: `spi_test_responder`

## Requirements
- R1: The mode field CTRL[1:0] selects CPOL = bit 1 and CPHA = bit 0. With CPHA = 0 the slave samples on the first (leading) SCLK edge of each bit, and with CPHA = 1 on the second (trailing) edge. Data leaves the slave so that the master can sample it on that same edge.
- R2: CTRL[2] = 0 sends and receives each symbol most significant bit first. CTRL[2] = 1 sends and receives it least significant bit first.
- R3: CTRL[8:4] holds the symbol width minus one, so symbols of 1 to 32 bits are supported.
- R4: In full duplex (CTRL[3] = 0), each symbol returned on MISO equals the symbol received in the previous slot of the same transfer. The first symbol of every transfer is returned as zero.
- R5: In half duplex (CTRL[3] = 1), register 1 holds the receive count in bits [15:0] and the transmit count in bits [31:16]. The slave takes the receive count of symbols from the `mosi` line without driving `sio_oe`. It then drives the transmit count of symbols on `sio_out` with `sio_oe` high, each symbol equal to the last one received (zero if none was received), and then lowers `sio_oe` while CS_n is still low.
- R6: `miso_oe` and `sio_oe` are low whenever `cs_n` is high. `miso_oe` is used only in full duplex and `sio_oe` only in half duplex.
- R7: The transfer counter (register 2, bits [15:0]) increments by one after each rising edge of `cs_n` that ends a transfer in which at least one full symbol was sent or received. A transfer with no complete symbol leaves it unchanged.
- R8: The checksum (register 3) adds every byte of each fully received symbol. The symbol is zero-extended to the next multiple of 8 bits before its bytes are added. Partial symbols and symbols the slave itself transmits in half duplex add nothing.
- R9: Writing register 0 with bit 31 set clears the transfer counter and the checksum on the following clock. The other control fields take the written value.
- R10: The register map is: 0 control, 1 half-duplex counts, 2 transfer counter, 3 checksum. `reg_rdata` shows the addressed word on the clock after `reg_re` is high. Bit 31 of the control word reads as zero.
- R11: After reset, all four registers read zero and both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one clock after reg_re |
| sclk | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | Master data line, shared data line in half duplex |
| miso_out | output | 1 | Slave data out in full duplex |
| miso_oe | output | 1 | Drive enable for miso_out |
| sio_out | output | 1 | Slave data driven onto the shared line in half duplex |
| sio_oe | output | 1 | Drive enable for sio_out |

## Verification
The bench sweeps all four clock modes against both bit orders with random widths and data. It includes the one-bit and full 32-bit symbol widths. A design that sampled on the wrong edge, indexed bits in the wrong order, or mis-set the width would return corrupted echoes or a wrong byte sum. Transfers that end mid-symbol, or that carry no clock at all, must leave the counter and the checksum alone; a design that counted on CS_n alone would fail here. The half-duplex cases cover an empty receive phase, an empty transmit phase and a multi-symbol turnaround. A late or missing bus release, or an echo of the wrong symbol, shows up at the pins.

// File: rtl/spi_resp_pkg.sv
package spi_resp_pkg;

   localparam int REG_W = 32;

   // control word layout
   localparam int CTL_MODE_LSB  = 0;
   localparam int CTL_ORDER_BIT = 2;
   localparam int CTL_HALF_BIT  = 3;
   localparam int CTL_WID_LSB   = 4;
   localparam int CTL_CLR_BIT   = 31;

   // half-duplex count word layout
   localparam int HDC_RX_LSB = 0;
   localparam int HDC_TX_LSB = 16;

   typedef enum logic [1:0] {
      ADR_CTRL  = 2'd0,
      ADR_HDCNT = 2'd1,
      ADR_XFERS = 2'd2,
      ADR_CSUM  = 2'd3
   } reg_addr_e;

   typedef enum logic [1:0] {
      PH_RECV = 2'd0,
      PH_SEND = 2'd1,
      PH_IDLE = 2'd2
   } phase_e;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_pin,
   input  logic mosi_pin,
   input  logic csn_pin,
   output logic sclk_rise,
   output logic sclk_fall,
   output logic mosi_s,
   output logic cs_act,
   output logic cs_start,
   output logic cs_end
);

   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sclk_q, mosi_q, csn_q;
   logic              sclk_d, csn_d;
   logic              sclk_s, csn_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= '0;
         mosi_q <= '0;
         csn_q  <= '1;
         sclk_d <= 1'b0;
         csn_d  <= 1'b1;
      end else begin
         sclk_q <= {sclk_q[STAGES-2:0], sclk_pin};
         mosi_q <= {mosi_q[STAGES-2:0], mosi_pin};
         csn_q  <= {csn_q[STAGES-2:0], csn_pin};
         sclk_d <= sclk_s;
         csn_d  <= csn_s;
      end
   end

   always_comb begin
      sclk_s    = sclk_q[STAGES-1];
      csn_s     = csn_q[STAGES-1];
      mosi_s    = mosi_q[STAGES-1];
      sclk_rise = sclk_s & ~sclk_d;
      sclk_fall = ~sclk_s & sclk_d;
      cs_act    = ~csn_s;
      cs_start  = ~csn_s & csn_d;
      cs_end    = csn_s & ~csn_d;
   end

endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
   import spi_resp_pkg::*;
#(
   parameter  int MAX_W = 32,
   parameter  int CNT_W = 16,
   localparam int WM_W  = $clog2(MAX_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode,
   input  logic             lsb_first,
   input  logic             half_dup,
   input  logic [WM_W-1:0]  wm1,
   input  logic [CNT_W-1:0] rx_limit,
   input  logic [CNT_W-1:0] tx_limit,
   input  logic             sclk_rise,
   input  logic             sclk_fall,
   input  logic             line_bit,
   input  logic             cs_act,
   input  logic             cs_start,
   input  logic             cs_end,
   output logic             tx_bit,
   output logic             sending,
   output logic             sym_done,
   output logic [MAX_W-1:0] sym_word,
   output logic             xfer_done
);

   if (MAX_W != (1 << WM_W) || MAX_W < 8) begin : g_bad_width
      $error("spi_shift_core: MAX_W must be a power of two, at least 8");
   end

   phase_e            phase, start_phase;
   logic [WM_W-1:0]   bit_cnt, idx;
   logic [CNT_W-1:0]  sym_cnt;
   logic [MAX_W-1:0]  rx_word, tx_word, rx_next, bit_hot;
   logic              got_sym;
   logic              samp_rise, sample, engaged, last_bit;

   always_comb begin
      samp_rise = (mode[1] == mode[0]);
      sample    = cs_act && !cs_start && (samp_rise ? sclk_rise : sclk_fall);
      engaged   = !half_dup || (phase != PH_IDLE);
      idx       = lsb_first ? bit_cnt : (wm1 - bit_cnt);
      bit_hot   = {{(MAX_W-1){1'b0}}, line_bit} << idx;
      rx_next   = ((bit_cnt == '0) ? '0 : rx_word) | bit_hot;
      last_bit  = (bit_cnt == wm1);
      tx_bit    = tx_word[idx];
      sending   = (phase == PH_SEND);
      if (!half_dup || rx_limit != '0) start_phase = PH_RECV;
      else if (tx_limit != '0)         start_phase = PH_SEND;
      else                             start_phase = PH_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         bit_cnt   <= '0;
         sym_cnt   <= '0;
         rx_word   <= '0;
         tx_word   <= '0;
         got_sym   <= 1'b0;
         sym_done  <= 1'b0;
         sym_word  <= '0;
         xfer_done <= 1'b0;
      end else begin
         sym_done  <= 1'b0;
         xfer_done <= cs_end & got_sym;
         if (cs_start) begin
            phase   <= start_phase;
            bit_cnt <= '0;
            sym_cnt <= '0;
            rx_word <= '0;
            tx_word <= '0;
            got_sym <= 1'b0;
         end else if (cs_end) begin
            phase   <= PH_IDLE;
            bit_cnt <= '0;
            tx_word <= '0;
         end else if (sample && engaged) begin
            if (!last_bit) begin
               bit_cnt <= bit_cnt + 1'b1;
               rx_word <= rx_next;
            end else begin
               bit_cnt <= '0;
               got_sym <= 1'b1;
               if (!half_dup) begin
                  sym_done <= 1'b1;
                  sym_word <= rx_next;
                  tx_word  <= rx_next;
               end else if (phase == PH_RECV) begin
                  sym_done <= 1'b1;
                  sym_word <= rx_next;
                  tx_word  <= rx_next;
                  if (sym_cnt + 1'b1 == rx_limit) begin
                     sym_cnt <= '0;
                     phase   <= (tx_limit != '0) ? PH_SEND : PH_IDLE;
                  end else begin
                     sym_cnt <= sym_cnt + 1'b1;
                  end
               end else begin
                  if (sym_cnt + 1'b1 == tx_limit) begin
                     sym_cnt <= '0;
                     phase   <= PH_IDLE;
                  end else begin
                     sym_cnt <= sym_cnt + 1'b1;
                  end
               end
            end
         end
      end
   end

endmodule

// File: rtl/spi_tally.sv
module spi_tally #(
   parameter  int MAX_W = 32,
   parameter  int CNT_W = 16,
   parameter  int SUM_W = 32,
   localparam int NB    = MAX_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             sym_done,
   input  logic [MAX_W-1:0] sym_word,
   input  logic             xfer_done,
   output logic [CNT_W-1:0] xfer_cnt,
   output logic [SUM_W-1:0] csum
);

   if (SUM_W <= 8 || (MAX_W % 8) != 0) begin : g_bad_sum
      $error("spi_tally: SUM_W must exceed 8 and MAX_W be whole bytes");
   end

   logic [7:0]       lane [NB];
   logic [SUM_W-1:0] byte_sum;

   for (genvar g = 0; g < NB; g++) begin : g_lane
      assign lane[g] = sym_word[8*g +: 8];
   end

   always_comb begin
      byte_sum = '0;
      for (int i = 0; i < NB; i++) begin
         byte_sum = byte_sum + {{(SUM_W-8){1'b0}}, lane[i]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_cnt <= '0;
         csum     <= '0;
      end else if (clear) begin
         xfer_cnt <= '0;
         csum     <= '0;
      end else begin
         if (xfer_done) xfer_cnt <= xfer_cnt + 1'b1;
         if (sym_done)  csum     <= csum + byte_sum;
      end
   end

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
   import spi_resp_pkg::*;
#(
   parameter int WM_W  = 5,
   parameter int CNT_W = 16,
   parameter int SUM_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic             reg_re,
   input  logic [1:0]       reg_addr,
   input  logic [REG_W-1:0] reg_wdata,
   input  logic [CNT_W-1:0] xfer_cnt,
   input  logic [SUM_W-1:0] csum,
   output logic [1:0]       mode,
   output logic             lsb_first,
   output logic             half_dup,
   output logic [WM_W-1:0]  wm1,
   output logic [CNT_W-1:0] rx_limit,
   output logic [CNT_W-1:0] tx_limit,
   output logic             clr_pulse,
   output logic [REG_W-1:0] reg_rdata
);

   if (CNT_W > 16 || SUM_W > REG_W || CTL_WID_LSB + WM_W > CTL_CLR_BIT) begin : g_bad_fields
      $error("spi_cfg_regs: field widths exceed the register word");
   end

   logic [REG_W-1:0] ctrl_word, hdc_word, cnt_word, sum_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= '0;
         lsb_first <= 1'b0;
         half_dup  <= 1'b0;
         wm1       <= '0;
         rx_limit  <= '0;
         tx_limit  <= '0;
         clr_pulse <= 1'b0;
         reg_rdata <= '0;
      end else begin
         clr_pulse <= 1'b0;
         if (reg_we) begin
            case (reg_addr_e'(reg_addr))
               ADR_CTRL: begin
                  mode      <= reg_wdata[CTL_MODE_LSB +: 2];
                  lsb_first <= reg_wdata[CTL_ORDER_BIT];
                  half_dup  <= reg_wdata[CTL_HALF_BIT];
                  wm1       <= reg_wdata[CTL_WID_LSB +: WM_W];
                  clr_pulse <= reg_wdata[CTL_CLR_BIT];
               end
               ADR_HDCNT: begin
                  rx_limit <= reg_wdata[HDC_RX_LSB +: CNT_W];
                  tx_limit <= reg_wdata[HDC_TX_LSB +: CNT_W];
               end
               default: ;
            endcase
         end
         if (reg_re) begin
            case (reg_addr_e'(reg_addr))
               ADR_CTRL:  reg_rdata <= ctrl_word;
               ADR_HDCNT: reg_rdata <= hdc_word;
               ADR_XFERS: reg_rdata <= cnt_word;
               default:   reg_rdata <= sum_word;
            endcase
         end
      end
   end

   always_comb begin
      ctrl_word = '0;
      ctrl_word[CTL_MODE_LSB +: 2]     = mode;
      ctrl_word[CTL_ORDER_BIT]         = lsb_first;
      ctrl_word[CTL_HALF_BIT]          = half_dup;
      ctrl_word[CTL_WID_LSB +: WM_W]   = wm1;
      hdc_word = '0;
      hdc_word[HDC_RX_LSB +: CNT_W]    = rx_limit;
      hdc_word[HDC_TX_LSB +: CNT_W]    = tx_limit;
      cnt_word = '0;
      cnt_word[CNT_W-1:0]              = xfer_cnt;
      sum_word = '0;
      sum_word[SUM_W-1:0]              = csum;
   end

endmodule

// File: rtl/spi_test_responder.sv
module spi_test_responder
   import spi_resp_pkg::*;
#(
   parameter  int SYM_MAX     = 32,
   parameter  int CNT_W       = 16,
   parameter  int SUM_W       = 32,
   parameter  int SYNC_STAGES = 2,
   localparam int WM_W        = $clog2(SYM_MAX)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic        reg_re,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        sclk,
   input  logic        cs_n,
   input  logic        mosi,
   output logic        miso_out,
   output logic        miso_oe,
   output logic        sio_out,
   output logic        sio_oe
);

   if (SYM_MAX > REG_W) begin : g_bad_sym
      $error("spi_test_responder: SYM_MAX cannot exceed the register width");
   end

   logic [1:0]         mode;
   logic               lsb_first, half_dup, clr_pulse;
   logic [WM_W-1:0]    wm1;
   logic [CNT_W-1:0]   rx_limit, tx_limit, xfer_cnt;
   logic [SUM_W-1:0]   csum;
   logic               sclk_rise, sclk_fall, mosi_s, cs_act, cs_start, cs_end;
   logic               tx_bit, sending, sym_done, xfer_done;
   logic [SYM_MAX-1:0] sym_word;

   spi_cfg_regs #(.WM_W(WM_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .xfer_cnt(xfer_cnt),
      .csum(csum), .mode(mode), .lsb_first(lsb_first), .half_dup(half_dup),
      .wm1(wm1), .rx_limit(rx_limit), .tx_limit(tx_limit),
      .clr_pulse(clr_pulse), .reg_rdata(reg_rdata)
   );

   spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk_pin(sclk), .mosi_pin(mosi),
      .csn_pin(cs_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .mosi_s(mosi_s), .cs_act(cs_act), .cs_start(cs_start), .cs_end(cs_end)
   );

   spi_shift_core #(.MAX_W(SYM_MAX), .CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode(mode), .lsb_first(lsb_first),
      .half_dup(half_dup), .wm1(wm1), .rx_limit(rx_limit),
      .tx_limit(tx_limit), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
      .line_bit(mosi_s), .cs_act(cs_act), .cs_start(cs_start),
      .cs_end(cs_end), .tx_bit(tx_bit), .sending(sending),
      .sym_done(sym_done), .sym_word(sym_word), .xfer_done(xfer_done)
   );

   spi_tally #(.MAX_W(SYM_MAX), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_tally (
      .clk(clk), .rst_n(rst_n), .clear(clr_pulse), .sym_done(sym_done),
      .sym_word(sym_word), .xfer_done(xfer_done), .xfer_cnt(xfer_cnt),
      .csum(csum)
   );

   always_comb begin
      miso_oe  = ~cs_n & ~half_dup;
      sio_oe   = ~cs_n & half_dup & sending;
      miso_out = miso_oe & tx_bit;
      sio_out  = sio_oe & tx_bit;
   end

endmodule

// File: rtl/spi_test_responder_chk.sv
module spi_test_responder_chk #(
   parameter int CNT_W = 16,
   parameter int SUM_W = 32,
   parameter int SYM_MAX = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n,
   input logic             miso_oe,
   input logic             sio_oe,
   input logic             clr_pulse,
   input logic [CNT_W-1:0] xfer_cnt,
   input logic [SUM_W-1:0] csum
);

   localparam logic [SUM_W-1:0] MAX_STEP = SUM_W'((SYM_MAX / 8) * 255);

   assert_miso_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !miso_oe);

   assert_sio_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sio_oe);

   assert_one_driver_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({miso_oe, sio_oe}));

   assert_xfer_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_cnt != $past(xfer_cnt)) |->
         ((xfer_cnt == $past(xfer_cnt) + 1'b1) || (xfer_cnt == '0)));

   assert_csum_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (csum != $past(csum)) |->
         ((csum - $past(csum) <= MAX_STEP) || (csum == '0)));

   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_pulse |=> (xfer_cnt == '0 && csum == '0));

endmodule

bind spi_test_responder spi_test_responder_chk #(
   .CNT_W(CNT_W), .SUM_W(SUM_W), .SYM_MAX(SYM_MAX)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso_oe(miso_oe),
   .sio_oe(sio_oe), .clr_pulse(clr_pulse), .xfer_cnt(xfer_cnt), .csum(csum)
);

// File: tb/sim_spi_test_responder.sv
`timescale 1ns/1ps
module sim_spi_test_responder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0, reg_re = 1'b0;
   logic [1:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   logic        miso_out, miso_oe, sio_out, sio_oe;

   int          checks = 0;
   int          fails = 0;
   logic [15:0] exp_cnt = '0;
   logic [31:0] exp_sum = '0;
   logic [31:0] pat [8];
   int unsigned seed_v;

   always #2.5 clk = ~clk;

   spi_test_responder u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso_out(miso_out),
      .miso_oe(miso_oe), .sio_out(sio_out), .sio_oe(sio_oe)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic half_bit();
      wait_clk(8);
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_re = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_re = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [31:0] wmask(input int w);
      return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
   endfunction

   function automatic logic [31:0] bsum(input logic [31:0] v);
      return {24'd0, v[7:0]} + {24'd0, v[15:8]} + {24'd0, v[23:16]} + {24'd0, v[31:24]};
   endfunction

   function automatic logic [31:0] ctrl_val(input logic [1:0] md, input logic lsb,
                                             input logic hd, input int w);
      logic [31:0] d;
      d = '0;
      d[1:0] = md;
      d[2]   = lsb;
      d[3]   = hd;
      d[8:4] = 5'(w - 1);
      return d;
   endfunction

   task automatic set_cfg(input logic [1:0] md, input logic lsb, input logic hd, input int w);
      logic [31:0] r;
      wr(2'd0, ctrl_val(md, lsb, hd, w));
      sclk = md[1];
      wait_clk(6);
      rd(2'd0, r);
      chk("R10 R3 control readback", r, ctrl_val(md, lsb, hd, w));
   endtask

   // One symbol as the master: R1 edge placement, R2 bit order.
   task automatic shift_sym(input logic [1:0] md, input logic lsb, input int w,
                            input logic [31:0] d, input logic from_sio, input logic drive,
                            output logic [31:0] got, output logic oe_all, output logic oe_any);
      got = '0; oe_all = 1'b1; oe_any = 1'b0;
      for (int k = 0; k < w; k++) begin
         int pos;
         logic b, oe;
         pos = lsb ? k : (w - 1 - k);
         if (!md[0]) begin
            mosi = drive ? d[pos] : 1'b0;
            half_bit();
            sclk = ~md[1];
            b  = from_sio ? sio_out : miso_out;
            oe = from_sio ? sio_oe : miso_oe;
            half_bit();
            sclk = md[1];
         end else begin
            sclk = ~md[1];
            mosi = drive ? d[pos] : 1'b0;
            half_bit();
            sclk = md[1];
            b  = from_sio ? sio_out : miso_out;
            oe = from_sio ? sio_oe : miso_oe;
            half_bit();
         end
         got[pos] = b;
         oe_all = oe_all & oe;
         oe_any = oe_any | oe;
      end
   endtask

   task automatic check_stats(input string tag);
      logic [31:0] r;
      rd(2'd2, r);
      chk({tag, " R7 transfer count"}, r, {16'd0, exp_cnt});
      rd(2'd3, r);
      chk({tag, " R8 checksum"}, r, exp_sum);
   endtask

   task automatic fd_run(input logic [1:0] md, input logic lsb, input int w, input int n);
      logic [31:0] got, prev;
      logic all, any;
      set_cfg(md, lsb, 1'b0, w);
      cs_n = 1'b0;
      wait_clk(10);
      prev = '0;
      for (int i = 0; i < n; i++) begin
         shift_sym(md, lsb, w, pat[i], 1'b0, 1'b1, got, all, any);
         chk($sformatf("R1 R2 R4 echo mode=%0d lsb=%0d w=%0d sym=%0d", md, lsb, w, i), got, prev);
         chk("R6 miso_oe held in full duplex", {31'd0, all}, 32'd1);
         prev = pat[i] & wmask(w);
         exp_sum = exp_sum + bsum(prev);
      end
      half_bit();
      cs_n = 1'b1;
      if (n > 0) exp_cnt = exp_cnt + 16'd1;
      wait_clk(12);
      chk("R6 outputs released with cs_n high", {30'd0, miso_oe, sio_oe}, 32'd0);
      check_stats("full duplex");
   endtask

   task automatic hd_run(input logic [1:0] md, input logic lsb, input int w,
                         input int nrx, input int ntx);
      logic [31:0] got, last;
      logic all, any;
      wr(2'd1, {16'(ntx), 16'(nrx)});
      set_cfg(md, lsb, 1'b1, w);
      cs_n = 1'b0;
      wait_clk(10);
      last = '0;
      for (int i = 0; i < nrx; i++) begin
         shift_sym(md, lsb, w, pat[i], 1'b1, 1'b1, got, all, any);
         chk("R5 shared line not driven while receiving", {31'd0, any}, 32'd0);
         chk("R6 miso_oe unused in half duplex", {31'd0, miso_oe}, 32'd0);
         last = pat[i] & wmask(w);
         exp_sum = exp_sum + bsum(last);
      end
      for (int j = 0; j < ntx; j++) begin
         shift_sym(md, lsb, w, 32'd0, 1'b1, 1'b0, got, all, any);
         chk($sformatf("R5 reply mode=%0d lsb=%0d w=%0d sym=%0d", md, lsb, w, j), got, last);
         chk("R5 shared line driven while sending", {31'd0, all}, 32'd1);
      end
      half_bit();
      chk("R5 line released after send phase", {31'd0, sio_oe}, 32'd0);
      cs_n = 1'b1;
      if (nrx + ntx > 0) exp_cnt = exp_cnt + 16'd1;
      wait_clk(12);
      check_stats("half duplex");
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] r;
      logic [31:0] got;
      logic all, any;
      seed_v = $urandom(32'd7331);
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(2);

      // R11 reset state
      for (int a = 0; a < 4; a++) begin
         rd(2'(a), r);
         chk($sformatf("R11 reset reg %0d", a), r, 32'd0);
      end
      chk("R11 enables low after reset", {30'd0, miso_oe, sio_oe}, 32'd0);

      // directed full duplex, 8-bit, mode 0, MSB first
      pat[0] = 32'hA5; pat[1] = 32'h3C; pat[2] = 32'hFF;
      fd_run(2'd0, 1'b0, 8, 3);

      // every mode against both orders, random width and data
      for (int m = 0; m < 4; m++) begin
         for (int o = 0; o < 2; o++) begin
            for (int i = 0; i < 8; i++) pat[i] = $urandom;
            fd_run(2'(m), o[0], $urandom_range(1, 32), $urandom_range(1, 3));
         end
      end

      // R3 width extremes
      pat[0] = 32'hDEADBEEF; pat[1] = 32'h80000001; pat[2] = 32'h12345678;
      fd_run(2'd3, 1'b1, 32, 3);
      pat[0] = 32'h1; pat[1] = 32'h0; pat[2] = 32'h1; pat[3] = 32'h1;
      fd_run(2'd1, 1'b0, 1, 4);
      pat[0] = 32'hABC; pat[1] = 32'hFFF;
      fd_run(2'd2, 1'b0, 12, 2);

      // R7 R8 partial symbol: no count, no sum
      set_cfg(2'd0, 1'b0, 1'b0, 8);
      cs_n = 1'b0;
      wait_clk(10);
      shift_sym(2'd0, 1'b0, 3, 32'h7, 1'b0, 1'b1, got, all, any);
      half_bit();
      cs_n = 1'b1;
      wait_clk(12);
      check_stats("partial symbol");

      // R7 select pulse with no clock
      cs_n = 1'b0;
      wait_clk(20);
      cs_n = 1'b1;
      wait_clk(12);
      check_stats("empty select");

      // half duplex cases
      pat[0] = 32'h5A; pat[1] = 32'hC3;
      hd_run(2'd1, 1'b0, 8, 2, 3);
      hd_run(2'd0, 1'b1, 8, 0, 2);
      pat[0] = 32'h2F1;
      hd_run(2'd3, 1'b0, 10, 1, 0);
      for (int i = 0; i < 8; i++) pat[i] = $urandom;
      hd_run(2'd2, 1'b1, $urandom_range(1, 32), 2, 1);

      // R10 half-duplex count readback
      rd(2'd1, r);
      chk("R10 count word readback", r, {16'd1, 16'd2});

      // R9 clear
      wr(2'd0, ctrl_val(2'd0, 1'b0, 1'b0, 16) | 32'h8000_0000);
      wait_clk(2);
      exp_cnt = '0;
      exp_sum = '0;
      check_stats("R9 clear");
      rd(2'd0, r);
      chk("R9 R10 fields written with clear, bit 31 reads zero", r, ctrl_val(2'd0, 1'b0, 1'b0, 16));

      // traffic after clear
      pat[0] = 32'h0102; pat[1] = 32'hFFFF;
      fd_run(2'd0, 1'b0, 16, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule